// File: doc/BRIEF.md
# Single-Slope Converter Comparator Control

This block is the digital half of a low-cost single-slope analog-to-digital converter. One memory-mapped control byte selects which of seven sources feeds the positive side of an external comparator. It also turns on a constant current source that charges an external capacitor, can pull the charge node low to empty that capacitor, and can send the comparator result to a pin. One master enable bit gates every one of these functions.

The comparator result can also be routed into a free-running capture timer. The timer synchronizes the routed signal and copies its count into a capture register on each rising edge. Software starts charging the capacitor and then reads the captured count, so the charge time becomes a digital value. The analog parts (comparator, current source, reference) sit outside this block and appear here as plain digital signals.

Top module: `slope_adc_ctl`

## Requirements
- R1: The control register sits at address 0. A write there stores the byte, and a read there returns the stored byte unchanged, gating does not alter it. Bit layout: bit 7 = timer routing, bits 6:4 = input select, bit 3 = output enable, bit 2 = current-source enable, bit 1 = comparator enable, bit 0 = discharge.
- R2: Reset clears the control register to 0x00 and clears the capture register and the capture flag.
- R3: While the comparator enable is 0, the following are all held at 0: cmp_on, isrc_on, dischg_on, pos_sel, both pin output enables, pin_out and the timer input. The other control bits have no effect.
- R4: While enabled, pos_sel is one-hot from the select code. Codes 0..5 set bits 0..5 (channel pins I0, I2, I3, I4, I5, I6 in that order), code 6 sets bit 6 (internal reference), and code 7 sets no bit.
- R5: With both the comparator enable and the output enable set, select code 2 sets pin_i7_oe and every other code sets pin_i3_oe. pin_out then follows cmp_in. With the output enable clear, neither pin enable is set and pin_out is 0.
- R6: isrc_on is the comparator enable AND bit 2. dischg_on is the comparator enable AND bit 0. cmp_on equals bit 1.
- R7: Address 1 reads the port status byte. Bit 1 is cmp_in while the comparator is enabled and 0 otherwise. Bit 7 is the capture flag. All other bits read 0.
- R8: With the enable and routing bits both set, a rising edge of cmp_in is passed through a two-flop synchronizer. It then copies the 16-bit free-running count (counting up every clock from 0 at reset) into the capture register and sets the capture flag. The capture register reads back as its low byte at address 2 and its high byte at address 3. Two captures differ by exactly the number of clocks between the two input edges.
- R9: Writing a byte with bit 7 = 1 to address 1 clears the capture flag. Writing bit 7 = 0 leaves the flag unchanged.
- R10: With routing clear, or with the comparator disabled, edges on cmp_in make no capture and leave the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_in | input | 1 | Result from the external comparator |
| cmp_on | output | 1 | Powers the comparator and reference |
| isrc_on | output | 1 | Turns on the charging current source |
| dischg_on | output | 1 | Pulls the charge node low |
| pos_sel | output | 7 | One-hot positive-input select |
| pin_i3_oe | output | 1 | Drives the comparator result onto pin I3 |
| pin_i7_oe | output | 1 | Drives the comparator result onto pin I7 |
| pin_out | output | 1 | Result value for the enabled pin |

## Verification
The assertions assume that cmp_in may change at any time relative to the clock, because the only path into clocked capture logic runs through the synchronizer. They also assume that bus writes to address 1 clear the flag only through bit 7. The stimulus changes cmp_in and bus fields on the falling clock edge. It holds cmp_in steady for several clocks around each edge it measures, so that the synchronizer latency is the same for both captures. It samples combinational read data half a period after setting the address.

// File: rtl/slope_pkg.sv
package slope_pkg;
   localparam int REG_W = 8;
   localparam int CAP_W = 16;
   localparam int NSEL  = 7;

   typedef struct packed {
      logic       route;
      logic [2:0] sel;
      logic       oe;
      logic       isrc;
      logic       en;
      logic       dis;
   } ctrl_t;

   localparam logic [2:0] SEL_PIN_I3 = 3'd2;

   localparam int ADR_CTRL = 0;
   localparam int ADR_PORT = 1;
   localparam int ADR_CAPL = 2;
   localparam int ADR_CAPH = 3;

   localparam int PORT_CMP_BIT  = 1;
   localparam int PORT_FLAG_BIT = 7;
endpackage

// File: rtl/slope_regs.sv
module slope_regs
   import slope_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              cmp_rd,
   input  logic              cap_flag,
   input  logic [CAP_W-1:0]  cap_val,
   output ctrl_t             ctrl,
   output logic              flag_clr
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(ADR_PORT);
   localparam logic [ADDR_W-1:0] A_CAPL = ADDR_W'(ADR_CAPL);
   localparam logic [ADDR_W-1:0] A_CAPH = ADDR_W'(ADR_CAPH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl <= '0;
      else if (bus_we && bus_addr == A_CTRL)
         ctrl <= ctrl_t'(bus_wdata);
   end

   assign flag_clr = bus_we && (bus_addr == A_PORT) && bus_wdata[PORT_FLAG_BIT];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL)
         bus_rdata = REG_W'(ctrl);
      else if (bus_addr == A_PORT) begin
         bus_rdata[PORT_CMP_BIT]  = cmp_rd;
         bus_rdata[PORT_FLAG_BIT] = cap_flag;
      end
      else if (bus_addr == A_CAPL)
         bus_rdata = cap_val[REG_W-1:0];
      else if (bus_addr == A_CAPH)
         bus_rdata = cap_val[CAP_W-1:REG_W];
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctrl == '0)) else $error("reset"); // R2
endmodule

// File: rtl/slope_gate.sv
module slope_gate
   import slope_pkg::*;
(
   input  ctrl_t            ctrl,
   input  logic             cmp_in,
   output logic             cmp_on,
   output logic             isrc_on,
   output logic             dischg_on,
   output logic [NSEL-1:0]  pos_sel,
   output logic             pin_i3_oe,
   output logic             pin_i7_oe,
   output logic             pin_out,
   output logic             tmr_in,
   output logic             cmp_rd
);
   logic drive;

   assign cmp_on    = ctrl.en;
   assign isrc_on   = ctrl.en & ctrl.isrc;
   assign dischg_on = ctrl.en & ctrl.dis;
   assign drive     = ctrl.en & ctrl.oe;
   assign pin_i7_oe = drive & (ctrl.sel == SEL_PIN_I3);
   assign pin_i3_oe = drive & (ctrl.sel != SEL_PIN_I3);
   assign pin_out   = drive & cmp_in;
   assign tmr_in    = ctrl.en & ctrl.route & cmp_in;
   assign cmp_rd    = ctrl.en & cmp_in;

   for (genvar g = 0; g < NSEL; g++) begin : g_sel
      assign pos_sel[g] = ctrl.en && (ctrl.sel == 3'(g));
   end
endmodule

// File: rtl/slope_capture.sv
module slope_capture #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_in,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cap,
   output logic             flag
);
   logic [CNT_W-1:0]     cnt;
   logic [SYNC_STAGES:0] chain;
   logic                 rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= tmr_in;
   end

   for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         cap  <= '0;
         flag <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
         if (rise) begin
            cap  <= cnt;
            flag <= 1'b1;
         end else if (flag_clr)
            flag <= 1'b0;
      end
   end

   AST_CAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> flag) else $error("flag"); // R8
   AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> (cap == $past(cnt))) else $error("cap"); // R8
   AST_CLR_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !rise) |=> !flag) else $error("clr"); // R9
endmodule

// File: rtl/slope_adc_ctl.sv
module slope_adc_ctl
   import slope_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              cmp_in,
   output logic              cmp_on,
   output logic              isrc_on,
   output logic              dischg_on,
   output logic [6:0]        pos_sel,
   output logic              pin_i3_oe,
   output logic              pin_i7_oe,
   output logic              pin_out
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (CNT_W < 8 || CNT_W > CAP_W) begin : g_bad_cnt
      $error("CNT_W must be in 8..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   ctrl_t            ctrl;
   logic             flag_clr, tmr_in, cmp_rd, cap_flag;
   logic [CNT_W-1:0] cap_raw;
   logic [CAP_W-1:0] cap_val;

   assign cap_val = CAP_W'(cap_raw);

   slope_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_rd(cmp_rd),
      .cap_flag(cap_flag), .cap_val(cap_val), .ctrl(ctrl), .flag_clr(flag_clr)
   );

   slope_gate gate_i (
      .ctrl(ctrl), .cmp_in(cmp_in), .cmp_on(cmp_on), .isrc_on(isrc_on),
      .dischg_on(dischg_on), .pos_sel(pos_sel), .pin_i3_oe(pin_i3_oe),
      .pin_i7_oe(pin_i7_oe), .pin_out(pin_out), .tmr_in(tmr_in), .cmp_rd(cmp_rd)
   );

   slope_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) cap_i (
      .clk(clk), .rst_n(rst_n), .tmr_in(tmr_in), .flag_clr(flag_clr),
      .cap(cap_raw), .flag(cap_flag)
   );

   AST_OFF_GATES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_on |-> !(isrc_on | dischg_on | pin_i3_oe | pin_i7_oe | pin_out | (|pos_sel)))
      else $error("gating"); // R3
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pos_sel)) else $error("sel"); // R4
   AST_ONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pin_i3_oe, pin_i7_oe})) else $error("pin"); // R5
   AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pin_i3_oe | pin_i7_oe) |-> !pin_out) else $error("pinout"); // R5
endmodule

// File: tb/slope_adc_ctl_tb.sv
`timescale 1ns/100ps
module slope_adc_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cmp_in = 1'b0;
   logic       cmp_on, isrc_on, dischg_on, pin_i3_oe, pin_i7_oe, pin_out;
   logic [6:0] pos_sel;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   slope_adc_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
      .cmp_on(cmp_on), .isrc_on(isrc_on), .dischg_on(dischg_on),
      .pos_sel(pos_sel), .pin_i3_oe(pin_i3_oe), .pin_i7_oe(pin_i7_oe),
      .pin_out(pin_out)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [7:0] outs();
      return {1'b0, cmp_on, isrc_on, dischg_on, pin_i3_oe, pin_i7_oe, pin_out, |pos_sel};
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      rd(2'd0, d); check("R2 ctrl", d, 8'h00);
      rd(2'd1, d); check("R2 port", d, 8'h00);
      rd(2'd2, d); check("R2 capl", d, 8'h00);
      check("R2 outputs", outs(), 8'h00);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(2'd0, 8'hA5); rd(2'd0, d); check("R1 readback A5", d, 8'hA5);
      wr(2'd0, 8'h5A); rd(2'd0, d); check("R1 readback 5A", d, 8'h5A);
   endtask

   task automatic t_gating_off();
      wr(2'd0, 8'hFD);          // every bit except the enable
      cmp_in = 1'b1;
      idle(2);
      check("R3 disabled outputs", outs(), 8'h00);
      cmp_in = 1'b0;
   endtask

   task automatic t_enables();
      wr(2'd0, 8'h06); // en + isrc
      check("R6 isrc", {cmp_on, isrc_on, dischg_on}, 3'b110);
      wr(2'd0, 8'h03); // en + dis
      check("R6 dischg", {cmp_on, isrc_on, dischg_on}, 3'b101);
   endtask

   task automatic t_select();
      for (int c = 0; c < 8; c++) begin
         wr(2'd0, 8'(c << 4) | 8'h02);
         check($sformatf("R4 sel code %0d", c), 16'(pos_sel), (c < 7) ? 16'(1 << c) : 16'h0);
      end
   endtask

   task automatic t_outpin();
      wr(2'd0, 8'h2A);           // sel 2, oe, en
      cmp_in = 1'b1; #1;
      check("R5 code2 -> I7", {pin_i3_oe, pin_i7_oe, pin_out}, 3'b011);
      wr(2'd0, 8'h4A);           // sel 4, oe, en
      #1 check("R5 code4 -> I3", {pin_i3_oe, pin_i7_oe, pin_out}, 3'b101);
      cmp_in = 1'b0; #1;
      check("R5 out follows", pin_out, 1'b0);
      wr(2'd0, 8'h42); cmp_in = 1'b1; #1;
      check("R5 oe clear", {pin_i3_oe, pin_i7_oe, pin_out}, 3'b000);
      cmp_in = 1'b0;
   endtask

   task automatic t_readback();
      logic [7:0] d;
      wr(2'd0, 8'h02); cmp_in = 1'b1;
      rd(2'd1, d); check("R7 port cmp high", d & 8'h02, 8'h02);
      cmp_in = 1'b0;
      rd(2'd1, d); check("R7 port cmp low", d & 8'h02, 8'h00);
      wr(2'd0, 8'h00); cmp_in = 1'b1;
      rd(2'd1, d); check("R7 disabled reads 0", d & 8'h02, 8'h00);
      cmp_in = 1'b0;
   endtask

   task automatic t_noroute();
      logic [7:0] d;
      wr(2'd1, 8'h80);
      wr(2'd0, 8'h02);                       // enabled, no routing
      cmp_in = 1'b1; idle(6); cmp_in = 1'b0; idle(4);
      rd(2'd1, d); check("R10 no route no flag", d & 8'h80, 8'h00);
      wr(2'd0, 8'h80);                       // routing, disabled
      cmp_in = 1'b1; idle(6); cmp_in = 1'b0; idle(4);
      rd(2'd1, d); check("R10 disabled no flag", d & 8'h80, 8'h00);
   endtask

   task automatic t_capture();
      logic [7:0]  d, lo, hi;
      logic [15:0] a, b;
      cmp_in = 1'b0;
      wr(2'd0, 8'h86);           // route, en, isrc
      idle(4);
      wr(2'd1, 8'h80);
      @(negedge clk); cmp_in = 1'b1;   // first rise
      idle(10); cmp_in = 1'b0;
      rd(2'd1, d); check("R8 flag set", d & 8'h80, 8'h80);
      rd(2'd2, lo); rd(2'd3, hi); a = {hi, lo};
      wr(2'd1, 8'h00);
      rd(2'd1, d); check("R9 write 0 keeps flag", d & 8'h80, 8'h80);
      wr(2'd1, 8'h80);
      rd(2'd1, d); check("R9 write 1 clears flag", d & 8'h80, 8'h00);
      idle(37 - 10 - 9);               // second rise 37 clocks after first
      cmp_in = 1'b1;
      idle(8);
      rd(2'd2, lo); rd(2'd3, hi); b = {hi, lo};
      check("R8 capture delta", b - a, 16'd37);
      rd(2'd1, d); check("R8 flag again", d & 8'h80, 8'h80);
      cmp_in = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_gating_off();
      t_enables();
      t_select();
      t_outpin();
      t_readback();
      t_noroute();
      t_capture();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule